// File: doc/BRIEF.md
# Mixed-Sign Fractional Byte Multiplier

This unit multiplies two 8-bit operands and returns a 16-bit product together with a zero flag and a carry flag. A 3-bit mode code selects how the operands are interpreted: both unsigned, both two's complement, or the first two's complement and the second unsigned. Bit 2 of the code independently selects integer or fractional (1.7 format) output. Fractional output is the full product shifted left by one bit.

The surrounding execution stage raises `start` for one cycle with the operands and the mode. Two clock edges later the unit raises `done` for one cycle. The product and the flags are then valid and are held until the next result. The caller always writes the product to one fixed register pair: the high byte to the upper register and the low byte to the lower one. The unit takes a new operation on every cycle.

Top module: `fmul8_unit`

## Requirements
- R1: Mode code 3'b000 multiplies both operands as unsigned values; `product` is the 16-bit result.
- R2: Mode code 3'b001 multiplies both operands as two's-complement values; `product` is the low 16 bits of the signed result.
- R3: Mode code 3'b010 treats `opa` as two's complement and `opb` as unsigned; `product` is the low 16 bits of the signed result.
- R4: When mode bit 2 is 1, the operands are interpreted as bits 1:0 select, and `product` is the integer product shifted left by one: bit 0 is 0 and the integer product's bit 15 is dropped.
- R5: `flag_c` equals bit 15 of the integer product before any fractional shift.
- R6: `flag_z` is 1 exactly when the 16-bit `product` presented with it is zero.
- R7: `done` is high for one cycle, two rising edges after the edge that samples `start`. It pulses once per accepted start, including starts on consecutive cycles.
- R8: While `done` is low, `product`, `flag_z` and `flag_c` keep the values of the last result.
- R9: After a synchronous reset (`rst_n` low at a rising edge), `done`, `product`, `flag_z` and `flag_c` are all 0.
- R10: Mode bits 1:0 = 2'b11 behave as unsigned-by-unsigned (same as 2'b00), with bit 2 still selecting fractional output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operation request, sampled each rising edge |
| mode | input | 3 | Bit 2 fractional; bits 1:0 00 unsigned, 01 signed, 10 signed-by-unsigned, 11 as 00 |
| opa | input | 8 | First operand (multiplicand) |
| opb | input | 8 | Second operand (multiplier) |
| done | output | 1 | One-cycle strobe: result valid |
| product | output | 16 | Product, high byte to upper register of the pair |
| flag_z | output | 1 | Product-is-zero flag |
| flag_c | output | 1 | Bit 15 of the unshifted product |

## Verification
Every result falls due exactly two rising edges after the edge that samples `start`. The driver tags each expected item with the cycle count at which it must appear. The monitor samples on falling edges and requires each strobe to arrive in exactly that cycle with the predicted product and flags, and it flags any strobe with nothing pending. On the idle falling edges between strobes, the monitor also checks that the outputs still hold the last popped result. Back-to-back starts check that one result falls due on each following cycle.

// File: rtl/fmul_pkg.sv
// Shared types for the byte multiplier.
// Assumes: mode bits 1:0 pick operand interpretation, bit 2 fractional output.
package fmul_pkg;
    typedef enum logic [1:0] {
        KIND_UU  = 2'b00,
        KIND_SS  = 2'b01,
        KIND_SU  = 2'b10,
        KIND_RSV = 2'b11
    } kind_e;

    // Whether the first operand is read as two's complement.
    function automatic logic a_is_signed(input logic [1:0] k);
        return (k == KIND_SS) || (k == KIND_SU);
    endfunction

    // Whether the second operand is read as two's complement.
    function automatic logic b_is_signed(input logic [1:0] k);
        return (k == KIND_SS);
    endfunction
endpackage

// File: rtl/fmul_opsel.sv
// Operand extension: widens each operand by one bit, sign- or zero-extended
// according to the operand kind. Purely combinational.
// Assumes: kind 2'b11 is treated as unsigned-by-unsigned.
module fmul_opsel
    import fmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   kind,
    output logic [W:0]   ea,
    output logic [W:0]   eb
);
    // Extend both operands by one bit per the selected interpretation.
    always_comb begin
        ea = {a_is_signed(kind) & a[W-1], a};
        eb = {b_is_signed(kind) & b[W-1], b};
    end
endmodule

// File: rtl/fmul_array.sv
// Stage one: registers the extended operands, the fractional bit and a valid
// bit, then forms the full signed product of the registered operands.
// Assumes: operands arrive already extended to W+1 bits.
module fmul_array #(
    parameter int W = 8,
    localparam int PW = 2 * W,
    localparam int FW = 2 * (W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          frac_in,
    input  logic [W:0]    ea,
    input  logic [W:0]    eb,
    output logic          v1,
    output logic          frac1,
    output logic [PW-1:0] raw
);
    logic [W:0]           ea_q, eb_q;
    logic signed [FW-1:0] full;

    // Capture the request and its operands on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            frac1 <= 1'b0;
            ea_q  <= '0;
            eb_q  <= '0;
        end else begin
            v1 <= start;
            if (start) begin
                frac1 <= frac_in;
                ea_q  <= ea;
                eb_q  <= eb;
            end
        end
    end

    // Signed product of the extended operands; low PW bits carry the result.
    always_comb begin
        full = $signed(ea_q) * $signed(eb_q);
        raw  = full[PW-1:0];
    end

    // R7: a valid stage-one entry exists only one edge after a start
    // (the first cycle after reset is skipped so $past stays inside reset history)
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= rst_n;
    v1_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && v1 |-> $past(start));
endmodule

// File: rtl/fmul_flags.sv
// Stage two: applies the optional fractional shift, forms carry and zero, and
// registers product, flags and the done strobe. Outputs hold between results.
// Assumes: raw is the unshifted product of the operands captured in stage one.
module fmul_flags #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          v1,
    input  logic          frac1,
    input  logic [PW-1:0] raw,
    output logic          done,
    output logic [PW-1:0] prod,
    output logic          zf,
    output logic          cf
);
    logic [PW-1:0] shaped;
    logic          c_next, z_next;

    // Shape the result and derive the two flags from it.
    always_comb begin
        shaped = frac1 ? {raw[PW-2:0], 1'b0} : raw;
        c_next = raw[PW-1];
        z_next = (shaped == '0);
    end

    // Register the result when stage one is valid; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            prod <= '0;
            zf   <= 1'b0;
            cf   <= 1'b0;
        end else begin
            done <= v1;
            if (v1) begin
                prod <= shaped;
                zf   <= z_next;
                cf   <= c_next;
            end
        end
    end

    // R4
    frac_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v1 && frac1 |=> prod[0] == 1'b0);
    // R5
    carry_integer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v1 && !frac1 |=> cf == prod[PW-1]);
endmodule

// File: rtl/fmul8_unit.sv
// Top of the mixed-sign fractional byte multiplier. Two-edge pipeline:
// operands are extended and captured, then the product is shaped and flagged.
// Assumes: one request per cycle at most; caller writes the product to a fixed pair.
module fmul8_unit
    import fmul_pkg::*;
#(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic          done,
    output logic [PW-1:0] product,
    output logic          flag_z,
    output logic          flag_c
);
    logic [W:0]    ea, eb;
    logic          v1, frac1;
    logic [PW-1:0] raw;

    fmul_opsel #(.W(W)) u_opsel (
        .a(opa), .b(opb), .kind(mode[1:0]), .ea(ea), .eb(eb)
    );

    fmul_array #(.W(W)) u_array (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_in(mode[2]),
        .ea(ea), .eb(eb), .v1(v1), .frac1(frac1), .raw(raw)
    );

    fmul_flags #(.PW(PW)) u_flags (
        .clk(clk), .rst_n(rst_n), .v1(v1), .frac1(frac1), .raw(raw),
        .done(done), .prod(product), .zf(flag_z), .cf(flag_c)
    );

    // R7
    done_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 done);
    // R7
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start ##1 1'b1) |=> !done);
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag_z == (product == '0));
    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> $stable(product) && $stable(flag_z) && $stable(flag_c));
    // R1 R10
    unsigned_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1:0] == KIND_UU || mode[1:0] == KIND_RSV) |-> !ea[W] && !eb[W]);
endmodule

// File: tb/test_fmul8_unit.sv
module test_fmul8_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [7:0]  opa = 8'h00, opb = 8'h00;
    logic        done;
    logic [15:0] product;
    logic        flag_z, flag_c;

    always #4 clk = ~clk;

    fmul8_unit i_fmul8_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opa(opa),
        .opb(opb), .done(done), .product(product), .flag_z(flag_z), .flag_c(flag_c)
    );

    typedef struct {
        logic [15:0] p;
        logic        z;
        logic        c;
        int          due;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          n_chk = 0, n_bad = 0, cyc = 0;
    logic        finished = 1'b0;
    logic [15:0] last_p = 16'h0;
    logic        last_z = 1'b0, last_c = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements: R1 R2 R3 R4 R5 R6 R10.
    function automatic item_t model(input logic [2:0] m, input logic [7:0] a,
                                    input logic [7:0] b, input string tag);
        item_t it;
        int ai, bi, pr;
        logic [15:0] rw;
        ai = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
        bi = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
        pr = ai * bi;
        rw = pr[15:0];
        it.c = rw[15];
        it.p = m[2] ? {rw[14:0], 1'b0} : rw;
        it.z = (it.p == 16'h0);
        it.tag = tag;
        it.due = 0;
        return it;
    endfunction

    // Driver: present one request at a falling edge and push its expectation.
    task automatic drive(input logic [2:0] m, input logic [7:0] a,
                         input logic [7:0] b, input string tag);
        item_t it;
        it = model(m, a, b, tag);
        it.due = cyc + 2;
        start = 1'b1; mode = m; opa = a; opb = b;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pop and compare on each strobe, check holding otherwise.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R7", "strobe with nothing pending", 1, 0);
                end else begin
                    item_t e;
                    e = sbq.pop_front();
                    check(cyc == e.due, "R7", {"latency ", e.tag}, cyc, e.due);
                    check(product == e.p, e.tag, "product", product, e.p);
                    check(flag_c == e.c, "R5", {"carry ", e.tag}, flag_c, e.c);
                    check(flag_z == e.z, "R6", {"zero ", e.tag}, flag_z, e.z);
                    last_p = e.p; last_z = e.z; last_c = e.c;
                end
            end else if (rst_n && !start && sbq.size() == 0 && cyc > 4) begin
                check(product == last_p && flag_z == last_z && flag_c == last_c,
                      "R8", "hold between results", product, last_p);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "run hung", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        s = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(done == 1'b0 && product == 16'h0 && flag_z == 1'b0 && flag_c == 1'b0,
              "R9", "reset state", {done, flag_z, flag_c, product}, 0);
        drive(3'b000, 8'hFF, 8'hFF, "R1");       // 0xFE01, C=1
        drive(3'b000, 8'h00, 8'h37, "R1");       // zero
        drive(3'b001, 8'h80, 8'h80, "R2");       // 0x4000
        drive(3'b001, 8'hFF, 8'h02, "R2");       // -2 = 0xFFFE
        drive(3'b010, 8'h80, 8'hFF, "R3");       // -32640 = 0x8080
        drive(3'b010, 8'h7F, 8'hFF, "R3");       // 0x7E81
        drive(3'b101, 8'h80, 8'h80, "R4");       // 0x8000, C=0
        drive(3'b110, 8'h80, 8'hFF, "R4");       // 0x0100, C=1
        drive(3'b100, 8'hFF, 8'hFF, "R4");       // 0xFC02, C=1
        drive(3'b101, 8'h00, 8'h80, "R4");       // zero fractional
        drive(3'b011, 8'hC0, 8'hC0, "R10");      // 0x9000 unsigned
        drive(3'b111, 8'h81, 8'h02, "R10");      // 0x0204 frac unsigned
        repeat (4) @(negedge clk);               // R8 idle hold
        for (int i = 0; i < 60; i++) begin
            logic [7:0] x;
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
            x = s ^ 8'hA3;
            drive(3'(i % 8), s, x, "R7");
        end
        repeat (6) @(negedge clk);
        check(sbq.size() == 0, "R7", "all results delivered", sbq.size(), 0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule